// File: doc/BRIEF.md
# Four-Tap Fixed-Coefficient Low-Pass FIR Filter

This block is a transversal (direct-form) low-pass FIR filter with four taps whose 16-bit weights are fixed in hardware. The weights were chosen for a 16 kHz sample stream with a 2 kHz cutoff. The filter takes 8-bit unsigned samples, each marked by a valid strobe.

The current sample and three older ones are each multiplied by their own weight in a parallel AND-array multiplier. Each 24-bit product keeps only its seven most significant bits. This removes the 2^17 weight scaling. The four short products are summed by ripple-carry adders into a registered 9-bit result, which carries its own valid flag.

The block sits in a sampled-audio datapath. Upstream logic pulses the strobe once per sample. Downstream logic takes the result in the cycle after the strobe.

Top module: `fir4_lowpass`

## Requirements
- R1: While the active-low clear is low, out_valid is 0, out_sample is 0 and all three history registers hold zero. The clear takes effect at once, without waiting for a clock edge.
- R2: out_valid is 1 in the clock cycle that follows a rising edge at which in_valid was 1. In every other cycle it is 0.
- R3: At an accepted edge, out_sample becomes T(0x8000, x[n]) + T(0x23B9, x[n-1]) + T(0x650B, x[n-2]) + T(0x2669, x[n-3]). Here x[n] is the sample on in_sample at that edge, and x[n-k] is the k-th earlier accepted sample.
- R4: T(c, x) is bits [23:17] of the 24-bit unsigned product c*x, that is floor(c*x / 2^17). A product below 2^17 therefore contributes zero.
- R5: A single accepted sample of 255 followed by accepted zeros produces the outputs 63, 17, 50 and 19 in that order, and 0 after that.
- R6: An edge at which in_valid is 0 leaves the history unchanged, and out_sample keeps its value.
- R7: Until three samples have been accepted after a clear, the missing older samples count as zero in the sum.
- R8: out_sample never exceeds 149, which is the sum for four consecutive samples of 255. The 9-bit output never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear of history and output |
| in_valid | input | 1 | Marks in_sample as a new sample at this edge |
| in_sample | input | 8 | Unsigned input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_sample | output | 9 | Registered filter result |

## Verification
Each history register feeds exactly one output term. A wrong or stuck history value therefore shows up as a wrong out_sample within one to three accepted samples, one cycle after the strobe that brings it into the sum. The impulse makes each weight visible on its own. Random streams then cover sums in which all four terms are nonzero.

A history that shifts on an idle edge shows at the next accepted sample, because the terms appear offset by one position. A fault in the truncation or the adders shows in the very next result.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  localparam int SAMPLE_W  = 8;
  localparam int COEF_W    = 16;
  localparam int FRAC_BITS = 17;
  localparam int NUM_TAPS  = 4;
  localparam int PROD_W    = COEF_W + SAMPLE_W;
  localparam int TRUNC_W   = PROD_W - FRAC_BITS;
  localparam int SUM_W     = TRUNC_W + 2;
  localparam int HIST_N    = NUM_TAPS - 1;

  localparam logic [COEF_W-1:0] TAP_WEIGHT [NUM_TAPS] = '{
    16'h8000, 16'h23B9, 16'h650B, 16'h2669
  };

  // Keep the high bits of a product and drop the fractional scaling.
  function automatic logic [TRUNC_W-1:0] trunc_product(input logic [PROD_W-1:0] p);
    return p[PROD_W-1 -: TRUNC_W];
  endfunction

  // Largest result the filter can produce: every tap sees a full-scale sample.
  function automatic int unsigned max_result();
    longint unsigned acc;
    longint unsigned full;
    acc  = 0;
    full = (64'd1 << SAMPLE_W) - 1;
    for (int i = 0; i < NUM_TAPS; i++)
      acc += (longint'(TAP_WEIGHT[i]) * full) >> FRAC_BITS;
    return int'(acc);
  endfunction

endpackage

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic [WIDTH-1:0]            din,
  output logic [DEPTH-1:0][WIDTH-1:0] taps
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [WIDTH-1:0] stage_in;
    if (s == 0) begin : g_head
      assign stage_in = din;
    end else begin : g_body
      assign stage_in = taps[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        taps[s] <= '0;
      else if (shift_en)
        taps[s] <= stage_in;
    end
  end

endmodule

// File: rtl/fir4_and_array_mult.sv
module fir4_and_array_mult #(
  parameter int A_W = 16,
  parameter int B_W = 8,
  parameter logic [A_W-1:0] WEIGHT = '0,
  localparam int P_W = A_W + B_W
) (
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] prod
);

  logic [P_W-1:0] row [B_W];
  logic [P_W-1:0] acc [B_W+1];

  assign acc[0] = '0;

  for (genvar k = 0; k < B_W; k++) begin : g_row
    // One row of partial products: each weight bit ANDed with sample bit k.
    logic [A_W-1:0] and_bits;
    assign and_bits   = WEIGHT & {A_W{b[k]}};
    assign row[k]     = P_W'(and_bits) << k;
    assign acc[k+1]   = acc[k] + row[k];
  end

  assign prod = acc[B_W];

endmodule

// File: rtl/fir4_ripple_adder.sv
module fir4_ripple_adder #(
  parameter int W = 7
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half       = a[i] ^ b[i];
    assign sum[i]     = half ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (half & carry[i]);
  end

  assign sum[W] = carry[W];

endmodule

// File: rtl/fir4_lowpass.sv
module fir4_lowpass
  import fir4_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SUM_W-1:0]    out_sample
);

  // Named internal events, visible to the bound checker.
  logic                          sample_accept;
  logic [HIST_N-1:0][SAMPLE_W-1:0] history;
  logic [SAMPLE_W-1:0]           tap_in  [NUM_TAPS];
  logic [PROD_W-1:0]             tap_prod[NUM_TAPS];
  logic [TRUNC_W-1:0]            tap_term[NUM_TAPS];
  logic [TRUNC_W:0]              pair_lo;
  logic [TRUNC_W:0]              pair_hi;
  logic [SUM_W-1:0]              next_sum;

  assign sample_accept = in_valid;

  fir4_delay_line #(
    .WIDTH(SAMPLE_W),
    .DEPTH(HIST_N)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sample_accept),
    .din     (in_sample),
    .taps    (history)
  );

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    if (t == 0) begin : g_now
      assign tap_in[t] = in_sample;
    end else begin : g_old
      assign tap_in[t] = history[t-1];
    end

    fir4_and_array_mult #(
      .A_W   (COEF_W),
      .B_W   (SAMPLE_W),
      .WEIGHT(TAP_WEIGHT[t])
    ) u_mult (
      .b   (tap_in[t]),
      .prod(tap_prod[t])
    );

    assign tap_term[t] = trunc_product(tap_prod[t]);
  end

  fir4_ripple_adder #(.W(TRUNC_W)) u_add_lo (
    .a  (tap_term[0]),
    .b  (tap_term[1]),
    .sum(pair_lo)
  );

  fir4_ripple_adder #(.W(TRUNC_W)) u_add_hi (
    .a  (tap_term[2]),
    .b  (tap_term[3]),
    .sum(pair_hi)
  );

  fir4_ripple_adder #(.W(TRUNC_W+1)) u_add_out (
    .a  (pair_lo),
    .b  (pair_hi),
    .sum(next_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= sample_accept;
      if (sample_accept)
        out_sample <= next_sum;
    end
  end

endmodule

// File: rtl/fir4_lowpass_checker.sv
module fir4_lowpass_checker
  import fir4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [SUM_W-1:0] out_sample,
  input logic [SUM_W-1:0] next_sum
);

  localparam int unsigned PEAK = max_result();

  // R1: coming out of clear, the output is empty.
  a_r1_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_sample == '0));

  // R2: a strobe is answered one cycle later.
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: no answer without a strobe.
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: the register takes the adder-chain result at an accepted edge.
  a_r3_captures_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sample == $past(next_sum)));

  // R6: idle edges hold the output.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));

  // R8: the result stays within the full-scale bound.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_sample) <= PEAK));

endmodule

bind fir4_lowpass fir4_lowpass_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .next_sum  (next_sum)
);

// File: tb/fir4_lowpass_test.sv
module fir4_lowpass_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    valid;
    int    value;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic       out_valid;
  logic [8:0] out_sample;

  int applied = 0;
  int bad = 0;
  bit mon_en = 1'b0;

  exp_item_t sb[$];
  int h1, h2, h3, last_out;
  int weights[4] = '{32768, 9145, 25867, 9833};

  fir4_lowpass uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int term(input int w, input int x);
    return (w * x) / 131072;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    applied++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic model_clear();
    h1 = 0; h2 = 0; h3 = 0; last_out = 0;
    sb.delete();
  endtask

  // Driver: presents one cycle of input and queues the expected result.
  task automatic drive(input int x, input bit v, input string tag);
    exp_item_t it;
    @(negedge clk);
    in_valid  = v;
    in_sample = 8'(x);
    if (v) begin
      last_out = term(weights[0], x) + term(weights[1], h1)
               + term(weights[2], h2) + term(weights[3], h3);
      h3 = h2; h2 = h1; h1 = x;
    end
    it.valid = v;
    it.value = last_out;
    it.tag   = tag;
    sb.push_back(it);
  endtask

  // Monitor: after each rising edge, compare against the oldest queued item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_en && sb.size() > 0) begin
        exp_item_t it;
        it = sb.pop_front();
        check({it.tag, " out_valid"}, int'(out_valid), int'(it.valid));
        check({it.tag, " out_sample"}, int'(out_sample), it.value);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  task automatic enter_clear();
    @(posedge clk);
    #3;
    mon_en = 1'b0;
    rst_n  = 1'b0;
    #1;
    // R1 / R9 style: clear acts without a clock edge
    check("R1 async out_valid", int'(out_valid), 0);
    check("R1 async out_sample", int'(out_sample), 0);
    model_clear();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_sample", int'(out_sample), 0);
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R5: impulse reveals each truncated weight in tap order.
    drive(255, 1, "R5 impulse");
    drive(0, 1, "R5 tap1");
    drive(0, 1, "R5 tap2");
    drive(0, 1, "R5 tap3");
    drive(0, 1, "R5 tail");
    drive(0, 0, "R2 idle");
    @(posedge clk); #3;
    check("R5 model tap weights", term(weights[0],255)*1000000 + term(weights[1],255)*10000
          + term(weights[2],255)*100 + term(weights[3],255), 63175019);

    // R6: idle edges keep history and output.
    drive(200, 1, "R6 load");
    drive(77, 0, "R6 idle");
    drive(13, 0, "R6 idle");
    drive(99, 0, "R6 idle");
    drive(0, 1, "R6 history kept");
    drive(0, 1, "R6 history kept");
    drive(0, 0, "R2 idle");

    // R4: small samples whose products fall below one unit.
    for (int i = 1; i <= 8; i++) drive(i, 1, "R4 small");
    drive(0, 0, "R2 idle");

    // R1: asynchronous clear mid-stream, then R7 zero-filled history.
    drive(180, 1, "R3 prefill");
    drive(240, 1, "R3 prefill");
    drive(0, 0, "R2 idle");
    enter_clear();
    drive(200, 1, "R7 first");
    drive(100, 1, "R7 second");
    drive(50, 1, "R7 third");
    drive(25, 1, "R7 full");
    drive(0, 0, "R2 idle");

    // R8: full-scale run gives the largest result.
    for (int i = 0; i < 5; i++) drive(255, 1, "R8 full scale");
    drive(0, 0, "R2 idle");
    @(posedge clk); #3;
    check("R8 peak", int'(out_sample), 149);

    // R3 / R2: random stream with random gaps.
    for (int i = 0; i < 400; i++)
      drive(int'($urandom_range(0, 255)), ($urandom_range(0, 3) != 0), "R3 random");
    drive(0, 0, "R2 idle");
    repeat (3) @(posedge clk);
    #3;
    check("R2 queue drained", sb.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule